// File: doc/BRIEF.md
# Bus-to-Register-Bank Access Bridge

This block sits between a Wishbone bus master and a register bank. It accepts one single-word access at a time and turns it into a read strobe or a write strobe toward the bank. The master stays stalled until the bank signals that the access is complete. The bus cycle then ends with a one-cycle acknowledge. The bank confirms a read by presenting valid data and confirms a write by acknowledging the data. Decoding the address and holding the registers are left to the bank.

The bridge latches the address, the write data and the direction when the access is accepted. It holds them unchanged at the bank side until completion, so the bank can take several cycles to answer. A watchdog bounds that wait. A bank that never answers still produces an acknowledge, with zero read data, so the bus cannot lock up. When the master lowers the cycle signal, the bridge returns to its idle state at once, from any state.

Top module: `wbs_bank_bridge`

## Requirements
- R1: While the synchronous reset `rst_i` is high, and on the first cycle after it is released, `ack_o`, `stall_o`, `bank_rd` and `bank_wr` are low and `dat_o` is zero.
- R2: In idle, `bank_rd` and `bank_wr` stay low. `cyc_i` high with `stb_i` low starts no access, and `stall_o` stays low.
- R3: When `cyc_i` and `stb_i` are both high in idle, `stall_o` is high from the next cycle. `adr_i` and `dat_i` are latched onto `bank_addr` and `bank_wdata` in that cycle, and they stay stable until the acknowledge.
- R4: One cycle after the access is accepted, the latched `we_i` picks the strobe: 1 raises `bank_wr`, 0 raises `bank_rd`. The strobe stays high until completion, and the two strobes are never high together.
- R5: A read completes in a cycle where `bank_rd` and `bank_rvalid` are high. A write completes in a cycle where `bank_wr` and `bank_wack` are high. `ack_o` rises on the next cycle, so the acknowledge arrives L+3 cycles after the request is presented for a bank answering L cycles after its strobe rises. On a read, `dat_o` then carries the `bank_rdata` sampled at completion. On a write, `dat_o` reads zero.
- R6: `ack_o` lasts exactly one cycle and `stall_o` is low during it. `dat_o` holds its value after the acknowledge until the next completion.
- R7: If no completion handshake arrives by the 16th cycle of the strobe (parameter `WAIT_LIMIT`), the access ends anyway with `ack_o` and a zero `dat_o`. A write that times out is not taken by the bank. A handshake in that same 16th cycle wins over the timeout.
- R8: `cyc_i` low returns the bridge to idle on the next cycle from any state, with the strobes, `stall_o` and `ack_o` low. After an acknowledge, no new access starts until `cyc_i` has been low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cyc_i | input | 1 | Bus cycle valid |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Bus write enable |
| adr_i | input | ADDR_W | Bus address |
| dat_i | input | DATA_W | Bus write data |
| dat_o | output | DATA_W | Bus read data |
| ack_o | output | 1 | Bus acknowledge |
| stall_o | output | 1 | Bus stall |
| bank_addr | output | ADDR_W | Latched register address |
| bank_wdata | output | DATA_W | Latched write data |
| bank_wr | output | 1 | Write strobe to the bank |
| bank_rd | output | 1 | Read strobe to the bank |
| bank_rdata | input | DATA_W | Read data from the bank |
| bank_rvalid | input | 1 | Bank: read data valid |
| bank_wack | input | 1 | Bank: write taken |

## Verification
The bank's completion handshake and the watchdog expiry can land in the same cycle, which is the 16th cycle of the strobe. The bench provokes this with a bank model whose answer delay is set per access. A delay of 15 makes both events coincide, and the bench expects the real data to win, or for a write, the bank to store the word. A delay of 16 or more has only the expiry, and the bench expects zero data and an unchanged register. In every case the bench measures the acknowledge latency and compares it with a value computed from the delay.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_ACT  = 3'd1,
      ST_RD   = 3'd2,
      ST_WR   = 3'd3,
      ST_DONE = 3'd4,
      ST_HOLD = 3'd5
   } bstate_t;

endpackage

// File: rtl/wbb_watchdog.sv
module wbb_watchdog #(
   parameter int WAIT_LIMIT = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic expired
);
   localparam int CW = (WAIT_LIMIT > 2) ? $clog2(WAIT_LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(WAIT_LIMIT - 1);

   generate
      if (WAIT_LIMIT < 2) begin : g_bad_limit
         $error("wbb_watchdog: WAIT_LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign expired = run && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (run && !expired) begin
         cnt_q <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end

   // R7
   expire_drops_run_chk: assert property (@(posedge clk) disable iff (rst)
      expired |=> !run);

endmodule

// File: rtl/wbb_fsm.sv
module wbb_fsm
   import wbb_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic cyc,
   input  logic stb,
   input  logic we_q,
   input  logic rvalid,
   input  logic wack,
   input  logic expired,
   output logic cap,
   output logic fin,
   output logic fin_data,
   output logic rd_o,
   output logic wr_o,
   output logic ack_o,
   output logic stall_o
);
   bstate_t st_q, st_d;

   always_comb begin
      st_d     = st_q;
      cap      = 1'b0;
      fin      = 1'b0;
      fin_data = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (cyc && stb) begin
               st_d = ST_ACT;
               cap  = 1'b1;
            end
         end
         ST_ACT: begin
            if (!cyc)      st_d = ST_IDLE;
            else if (we_q) st_d = ST_WR;
            else           st_d = ST_RD;
         end
         ST_RD: begin
            if (!cyc) begin
               st_d = ST_IDLE;
            end else if (rvalid) begin
               st_d     = ST_DONE;
               fin      = 1'b1;
               fin_data = 1'b1;
            end else if (expired) begin
               st_d = ST_DONE;
               fin  = 1'b1;
            end
         end
         ST_WR: begin
            if (!cyc) begin
               st_d = ST_IDLE;
            end else if (wack || expired) begin
               st_d = ST_DONE;
               fin  = 1'b1;
            end
         end
         ST_DONE: begin
            st_d = cyc ? ST_HOLD : ST_IDLE;
         end
         ST_HOLD: begin
            if (!cyc) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_d;
   end

   assign rd_o    = (st_q == ST_RD);
   assign wr_o    = (st_q == ST_WR);
   assign ack_o   = (st_q == ST_DONE);
   assign stall_o = (st_q == ST_ACT) || (st_q == ST_RD) || (st_q == ST_WR);

   // R6
   ack_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ack_o |=> !ack_o);

   // R6
   ack_stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(ack_o && stall_o));

   // R4
   strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(rd_o && wr_o));

   // R5
   read_done_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_o && rvalid && cyc) |=> ack_o);

   // R5
   write_done_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_o && wack && cyc) |=> ack_o);

   // R8
   cyc_drop_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !cyc |=> (!stall_o && !ack_o && !rd_o && !wr_o));

   // R3
   accept_stalls_chk: assert property (@(posedge clk) disable iff (rst)
      (!stall_o && !ack_o && !$past(ack_o) && cyc && stb && !rd_o && !wr_o
       && $past(!cyc)) |=> stall_o);

endmodule

// File: rtl/wbb_latch.sv
module wbb_latch #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cap,
   input  logic              fin,
   input  logic              fin_data,
   input  logic              stall,
   input  logic              we_in,
   input  logic [ADDR_W-1:0] adr_in,
   input  logic [DATA_W-1:0] dat_in,
   input  logic [DATA_W-1:0] rdata_in,
   output logic              we_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdat_q
);
   generate
      if (ADDR_W < 1) begin : g_bad_aw
         $error("wbb_latch: ADDR_W must be positive");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("wbb_latch: DATA_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (cap) begin
         we_q    <= we_in;
         addr_q  <= adr_in;
         wdata_q <= dat_in;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)      rdat_q <= '0;
      else if (fin) rdat_q <= fin_data ? rdata_in : '0;
   end

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (stall && $past(stall)) |-> ($stable(addr_q) && $stable(wdata_q)));

   // R6
   rdat_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(fin) |-> $stable(rdat_q));

endmodule

// File: rtl/wbs_bank_bridge.sv
module wbs_bank_bridge #(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 8,
   parameter int WAIT_LIMIT = 16
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              cyc_i,
   input  logic              stb_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] adr_i,
   input  logic [DATA_W-1:0] dat_i,
   output logic [DATA_W-1:0] dat_o,
   output logic              ack_o,
   output logic              stall_o,
   output logic [ADDR_W-1:0] bank_addr,
   output logic [DATA_W-1:0] bank_wdata,
   output logic              bank_wr,
   output logic              bank_rd,
   input  logic [DATA_W-1:0] bank_rdata,
   input  logic              bank_rvalid,
   input  logic              bank_wack
);
   logic cap, fin, fin_data, we_q, expired;

   wbb_fsm u_fsm (
      .clk      (clk_i),
      .rst      (rst_i),
      .cyc      (cyc_i),
      .stb      (stb_i),
      .we_q     (we_q),
      .rvalid   (bank_rvalid),
      .wack     (bank_wack),
      .expired  (expired),
      .cap      (cap),
      .fin      (fin),
      .fin_data (fin_data),
      .rd_o     (bank_rd),
      .wr_o     (bank_wr),
      .ack_o    (ack_o),
      .stall_o  (stall_o)
   );

   wbb_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
      .clk      (clk_i),
      .rst      (rst_i),
      .cap      (cap),
      .fin      (fin),
      .fin_data (fin_data),
      .stall    (stall_o),
      .we_in    (we_i),
      .adr_in   (adr_i),
      .dat_in   (dat_i),
      .rdata_in (bank_rdata),
      .we_q     (we_q),
      .addr_q   (bank_addr),
      .wdata_q  (bank_wdata),
      .rdat_q   (dat_o)
   );

   wbb_watchdog #(.WAIT_LIMIT(WAIT_LIMIT)) u_wdog (
      .clk     (clk_i),
      .rst     (rst_i),
      .run     (bank_rd || bank_wr),
      .expired (expired)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk_i)
      $past(rst_i) |-> (!ack_o && !stall_o && !bank_rd && !bank_wr && dat_o == '0));

endmodule

// File: tb/sim_wbs_bank_bridge.sv
module sim_wbs_bank_bridge;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
   logic [3:0] adr = '0;
   logic [7:0] dat = '0;
   logic [7:0] dat_o, bank_wdata, bank_rdata;
   logic [3:0] bank_addr;
   logic ack, stall, bank_wr, bank_rd, bank_rvalid, bank_wack;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   int lat    = 0;
   int hold   = 0;
   logic [7:0] mem   [16];
   logic [7:0] model [16];

   always #10 clk = ~clk;

   wbs_bank_bridge u0 (
      .clk_i(clk), .rst_i(rst), .cyc_i(cyc), .stb_i(stb), .we_i(we),
      .adr_i(adr), .dat_i(dat), .dat_o(dat_o), .ack_o(ack), .stall_o(stall),
      .bank_addr(bank_addr), .bank_wdata(bank_wdata), .bank_wr(bank_wr),
      .bank_rd(bank_rd), .bank_rdata(bank_rdata), .bank_rvalid(bank_rvalid),
      .bank_wack(bank_wack)
   );

   // bank model: answers when its strobe has been high for lat cycles
   always @(posedge clk) hold <= (bank_rd || bank_wr) ? hold + 1 : 0;
   assign bank_rvalid = bank_rd && (hold == lat);
   assign bank_wack   = bank_wr && (hold == lat);
   assign bank_rdata  = mem[bank_addr];
   always @(posedge clk) if (bank_wr && bank_wack) mem[bank_addr] <= bank_wdata;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic access(input bit w, input logic [3:0] a, input logic [7:0] d, input int l);
      int n = 0;
      bit stall_ok = 1'b1;
      bit strobe_ok = 1'b1;
      int exp_n = (l <= 15) ? l + 3 : 18;
      logic [7:0] expd = (!w && l <= 15) ? model[a] : 8'h00;
      lat = l;
      @(negedge clk);
      cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat = d;
      do begin
         @(posedge clk);
         n++;
         @(negedge clk);
         adr = ~a; dat = ~d;
         if (!ack && !stall) stall_ok = 1'b0;
         if (n == 2 && !(w ? (bank_wr && !bank_rd) : (bank_rd && !bank_wr))) strobe_ok = 1'b0;
      end while (!ack && n < 40);
      // R5 R7: acknowledge latency
      chk(n == exp_n, "R5/R7 ack latency", n, exp_n);
      chk(dat_o == expd, "R5/R7 dat_o at ack", dat_o, expd);
      chk(stall_ok, "R3 stall held until ack", 0, 1);
      chk(strobe_ok, "R4 strobe type", 0, 1);
      chk(stall == 1'b0, "R6 stall low with ack", stall, 0);
      chk(bank_addr == a && (!w || bank_wdata == d), "R3 latched addr/data", bank_addr, a);
      if (w && l <= 15) model[a] = d;
      // R8: strobe kept high after ack must not start a new access
      @(posedge clk); @(negedge clk);
      chk(!ack && dat_o == expd, "R6 single ack, dat_o held", ack, 0);
      @(posedge clk); @(negedge clk);
      chk(!stall && !bank_rd && !bank_wr, "R8 no restart before cyc low", stall, 0);
      cyc = 1'b0; stb = 1'b0;
      @(posedge clk); @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem[i] = 8'h00;
         model[i] = 8'h00;
      end
      @(negedge clk);
      // R1 during reset
      chk(!ack && !stall && !bank_rd && !bank_wr && dat_o == 0, "R1 reset outputs", ack, 0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(!ack && !stall && !bank_rd && !bank_wr && dat_o == 0, "R1 after reset", stall, 0);

      // R2: cyc without stb does nothing
      cyc = 1'b1; stb = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(posedge clk); @(negedge clk);
         chk(!stall && !bank_rd && !bank_wr && !ack, "R2 idle without stb", stall, 0);
      end
      cyc = 1'b0;

      // write sweep and read-back sweep, varied bank delays
      for (int a = 0; a < 16; a++) access(1'b1, 4'(a), 8'(a * 37 + 5), a % 6);
      for (int a = 0; a < 16; a++) access(1'b0, 4'(a), 8'h00, (a * 3) % 7);

      // R7: handshake and expiry in the same cycle, then expiry alone
      access(1'b0, 4'd3, 8'h00, 15);
      access(1'b0, 4'd3, 8'h00, 16);
      access(1'b1, 4'd7, 8'hA5, 15);
      access(1'b1, 4'd8, 8'h5A, 40);
      access(1'b0, 4'd7, 8'h00, 1);
      access(1'b0, 4'd8, 8'h00, 2);

      // R8: abort a read by dropping cyc
      lat = 99;
      @(negedge clk);
      cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 4'd2;
      for (int i = 0; i < 5; i++) @(negedge clk);
      chk(bank_rd && stall, "R8 read in progress", bank_rd, 1);
      cyc = 1'b0; stb = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(!bank_rd && !stall && !ack, "R8 abort to idle", bank_rd, 0);
      access(1'b0, 4'd2, 8'h00, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule